// File: doc/BRIEF.md
# Dual-Interrupt GPIO Module with Wakeup

This block serves 32 general-purpose lines. Each line has an input pin and an output pin. A host reaches the block through a 32-bit register port with per-byte write enables. Each line can be an input or an output, chosen by an output-enable mask in which a 1 means input. An output line drives its stored data-out bit, and an input line drives 0.

Input lines are watched by four independent detectors: low level, high level, rising edge and falling edge. A qualifying event sets the line's bit in two sticky status banks at once. Each bank has its own enable mask and its own interrupt output, so two processors can service the same lines separately.

Level conditions are re-checked every cycle. A cleared status bit therefore comes back while its level still holds. A system-configuration register gates a wakeup request and carries a soft-reset command. It also rejects one illegal idle-mode encoding and reports the attempt on an error pulse.

Top module: `gpio_dual_irq`

## Requirements
- R1: After reset the output-enable register (byte offset 0x34) reads 0xFFFFFFFF. Every enable, status, detect, data-out and configuration register reads 0. Revision (0x00) reads the REV_ID parameter. Sysstatus (0x14) reads 1 from the second cycle after reset onward.
- R2: On a line whose output-enable bit is 1, an event sets the line's bit in both status registers (bank A at 0x18, bank B at 0x28) on the clock edge that samples the new pin value. An event is a 0-to-1 change of the pin with the rising-detect bit (0x48) set, or a 1-to-0 change with the falling-detect bit (0x4C) set.
- R3: A high pin with the high-level bit (0x44) set, or a low pin with the low-level bit (0x40) set, is an event on every cycle. Writing 1s to a status register clears those bits. A bit whose level condition still holds reads back as 1 after the clear.
- R4: Status bits are sticky until written with 1. A line whose output-enable bit is 0 never sets status.
- R5: irqA is high exactly when some bit is set in both bank-A status and bank-A enable (0x1C). irqB is the same for bank B (status 0x28, enable 0x2C).
- R6: pinOut bit i equals data-out bit i (0x3C) when output-enable bit i is 0, and is 0 otherwise. pinDrive is the inverse of output-enable.
- R7: Writing 1s sets or clears enable bits through aliases: 0x64/0x60 for bank A enable, 0x74/0x70 for bank B enable, 0x84/0x80 for wakeup enable, and 0x94/0x90 for data-out (set/clear). Zero bits leave the target unchanged, and every alias reads back its target register.
- R8: Sysconfig (0x10) stores the written value ANDed with 0x1D. A write whose idle field (bits 4:3) would become 3 changes nothing and raises cfgErr for one cycle. A legal write with bit 1 set returns all registers to their reset values, then stores the masked value.
- R9: wakeReq is set by an event on a line whose wakeup-enable bit (0x20) is set, but only while sysconfig bit 2 is 1 and the idle field is nonzero. It stays high until the next accepted sysconfig write.
- R10: For a write with some byte enables low, ordinary registers keep their unwritten bytes. For status registers and set/clear aliases, the unwritten bytes count as zero.
- R11: Revision, sysstatus and data-in (0x38) ignore writes. Data-in reads the pin values registered one cycle earlier. Control (0x30) keeps 3 bits, debounce time (0x54) keeps 8 bits, and debounce enable (0x50) keeps all lines. None of these three affects detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Register access valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Word address (byte offset bits 7:2) |
| busBe | input | 4 | Byte-lane write enables |
| busWdata | input | 32 | Write data, lanes in place |
| busRdata | output | 32 | Read data of the addressed word |
| pinIn | input | NUM_LINES | Input pins |
| pinOut | output | NUM_LINES | Output pin values |
| pinDrive | output | NUM_LINES | 1 where a line is an output |
| irqA | output | 1 | Interrupt for processor A |
| irqB | output | 1 | Interrupt for processor B |
| wakeReq | output | 1 | Wakeup request |
| cfgErr | output | 1 | One-cycle pulse on a rejected sysconfig write |

## Verification
The bench sweeps every line with a single detector enabled and checks that only that line's bit rises, in the bank it enabled. A decoder or generate index error would show up as a wrong bit or a wrong interrupt. It clears a status bit while its level still holds: a design that cleared it for good would read 0 and drop the interrupt. Byte-enable writes go to both an ordinary register and to write-1 registers. A design that merged the current value into an alias would set or clear bits in unwritten lanes, and one that did not merge would zero the kept bytes. The wakeup checks try each gate alone, and the sysconfig checks try the illegal idle code and the soft reset, so a missing gate, a stored illegal value or an incomplete reset each produces a mismatch.

// File: rtl/gpio_dual_irq_pkg.sv
package gpio_dual_irq_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned WIDX_W = 6;
  localparam int unsigned CFG_W  = 5;
  localparam logic [CFG_W-1:0] CFG_KEEP = 5'h1D;

  // word indices (byte offset / 4)
  localparam logic [WIDX_W-1:0] W_REV    = 6'h00; // 0x00
  localparam logic [WIDX_W-1:0] W_CFG    = 6'h04; // 0x10
  localparam logic [WIDX_W-1:0] W_SSTAT  = 6'h05; // 0x14
  localparam logic [WIDX_W-1:0] W_STATA  = 6'h06; // 0x18
  localparam logic [WIDX_W-1:0] W_ENA    = 6'h07; // 0x1C
  localparam logic [WIDX_W-1:0] W_WAKE   = 6'h08; // 0x20
  localparam logic [WIDX_W-1:0] W_STATB  = 6'h0A; // 0x28
  localparam logic [WIDX_W-1:0] W_ENB    = 6'h0B; // 0x2C
  localparam logic [WIDX_W-1:0] W_CTRL   = 6'h0C; // 0x30
  localparam logic [WIDX_W-1:0] W_OE     = 6'h0D; // 0x34
  localparam logic [WIDX_W-1:0] W_DIN    = 6'h0E; // 0x38
  localparam logic [WIDX_W-1:0] W_DOUT   = 6'h0F; // 0x3C
  localparam logic [WIDX_W-1:0] W_LOW    = 6'h10; // 0x40
  localparam logic [WIDX_W-1:0] W_HIGH   = 6'h11; // 0x44
  localparam logic [WIDX_W-1:0] W_RISE   = 6'h12; // 0x48
  localparam logic [WIDX_W-1:0] W_FALL   = 6'h13; // 0x4C
  localparam logic [WIDX_W-1:0] W_DBEN   = 6'h14; // 0x50
  localparam logic [WIDX_W-1:0] W_DBTIME = 6'h15; // 0x54
  localparam logic [WIDX_W-1:0] W_CLRENA = 6'h18; // 0x60
  localparam logic [WIDX_W-1:0] W_SETENA = 6'h19; // 0x64
  localparam logic [WIDX_W-1:0] W_CLRENB = 6'h1C; // 0x70
  localparam logic [WIDX_W-1:0] W_SETENB = 6'h1D; // 0x74
  localparam logic [WIDX_W-1:0] W_CLRWK  = 6'h20; // 0x80
  localparam logic [WIDX_W-1:0] W_SETWK  = 6'h21; // 0x84
  localparam logic [WIDX_W-1:0] W_CLRDO  = 6'h24; // 0x90
  localparam logic [WIDX_W-1:0] W_SETDO  = 6'h25; // 0x94

  typedef struct packed {
    logic [REG_W-1:0]  wdata;
    logic [REG_W-1:0]  mask;     // byte enables expanded to bits
    logic [WIDX_W-1:0] wordIdx;
    logic [CFG_W-1:0]  cfgNext;  // merged sysconfig candidate
    logic wrCfg;
    logic softRst;
    logic wrStatA;
    logic wrStatB;
    logic wrEnA;
    logic setEnA;
    logic clrEnA;
    logic wrEnB;
    logic setEnB;
    logic clrEnB;
    logic wrWake;
    logic setWake;
    logic clrWake;
    logic wrCtrl;
    logic wrOe;
    logic wrDout;
    logic setDout;
    logic clrDout;
    logic wrLow;
    logic wrHigh;
    logic wrRise;
    logic wrFall;
    logic wrDbEn;
    logic wrDbTime;
  } strobe_t;

endpackage

// File: rtl/gpio_dual_irq_detect.sv
module gpio_dual_irq_detect #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0] pinNow,
  input  logic [NUM_LINES-1:0] pinPrev,
  input  logic [NUM_LINES-1:0] isInput,
  input  logic [NUM_LINES-1:0] lowDet,
  input  logic [NUM_LINES-1:0] highDet,
  input  logic [NUM_LINES-1:0] riseDet,
  input  logic [NUM_LINES-1:0] fallDet,
  output logic [NUM_LINES-1:0] evt
);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic rose;
    logic fell;
    assign rose = pinNow[i] & ~pinPrev[i];
    assign fell = ~pinNow[i] & pinPrev[i];
    assign evt[i] = isInput[i] &
                    ((rose & riseDet[i]) | (fell & fallDet[i]) |
                     (pinNow[i] & highDet[i]) | (~pinNow[i] & lowDet[i]));
  end

endmodule

// File: rtl/gpio_dual_irq_ctrl.sv
module gpio_dual_irq_ctrl
  import gpio_dual_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWrite,
  input  logic [WIDX_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [REG_W-1:0]  busWdata,
  input  logic [CFG_W-1:0]  cfgCur,
  output strobe_t           strb,
  output logic              cfgErr
);

  logic             doWrite;
  logic [REG_W-1:0] laneMask;
  logic [CFG_W-1:0] cfgMerged;
  logic             cfgLegal;
  logic             cfgReject;

  assign doWrite  = busEn & busWrite;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign laneMask[8*b +: 8] = {8{busBe[b]}};
  end

  assign cfgMerged = (cfgCur & ~laneMask[CFG_W-1:0]) | (busWdata[CFG_W-1:0] & laneMask[CFG_W-1:0]);
  assign cfgLegal  = (cfgMerged[4:3] != 2'b11);
  assign cfgReject = doWrite && (busAddr == W_CFG) && !cfgLegal;

  always_comb begin
    strb         = '0;
    strb.wdata   = busWdata;
    strb.mask    = laneMask;
    strb.wordIdx = busAddr;
    strb.cfgNext = cfgMerged;
    if (doWrite) begin
      unique case (busAddr)
        W_CFG: begin
          strb.wrCfg   = cfgLegal;
          strb.softRst = cfgLegal & cfgMerged[1];
        end
        W_STATA:  strb.wrStatA  = 1'b1;
        W_STATB:  strb.wrStatB  = 1'b1;
        W_ENA:    strb.wrEnA    = 1'b1;
        W_SETENA: strb.setEnA   = 1'b1;
        W_CLRENA: strb.clrEnA   = 1'b1;
        W_ENB:    strb.wrEnB    = 1'b1;
        W_SETENB: strb.setEnB   = 1'b1;
        W_CLRENB: strb.clrEnB   = 1'b1;
        W_WAKE:   strb.wrWake   = 1'b1;
        W_SETWK:  strb.setWake  = 1'b1;
        W_CLRWK:  strb.clrWake  = 1'b1;
        W_CTRL:   strb.wrCtrl   = 1'b1;
        W_OE:     strb.wrOe     = 1'b1;
        W_DOUT:   strb.wrDout   = 1'b1;
        W_SETDO:  strb.setDout  = 1'b1;
        W_CLRDO:  strb.clrDout  = 1'b1;
        W_LOW:    strb.wrLow    = 1'b1;
        W_HIGH:   strb.wrHigh   = 1'b1;
        W_RISE:   strb.wrRise   = 1'b1;
        W_FALL:   strb.wrFall   = 1'b1;
        W_DBEN:   strb.wrDbEn   = 1'b1;
        W_DBTIME: strb.wrDbTime = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= cfgReject;
  end

endmodule

// File: rtl/gpio_dual_irq_dp.sv
module gpio_dual_irq_dp
  import gpio_dual_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter logic [REG_W-1:0] REV_ID = 32'h0000_0025
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [REG_W-1:0]     busRdata,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinDrive,
  output logic                 irqA,
  output logic                 irqB,
  output logic                 wakeReq,
  output logic [CFG_W-1:0]     cfgCur
);

  localparam int unsigned LW     = NUM_LINES;
  localparam int unsigned CTRL_W = 3;
  localparam int unsigned DBT_W  = 8;

  logic [LW-1:0] statA, statB, enA, enB, wakeEn;
  logic [LW-1:0] oeMask, doutQ, lowQ, highQ, riseQ, fallQ, dbEnQ, inReg;
  logic [CTRL_W-1:0] ctrlQ;
  logic [DBT_W-1:0]  dbTimeQ;
  logic [CFG_W-1:0]  cfgQ;
  logic              resetDone;
  logic [LW-1:0]     evt;
  logic [LW-1:0]     wMask, wData, w1;
  logic              wakeGate;

  assign wMask = strb.mask[LW-1:0];
  assign wData = strb.wdata[LW-1:0];
  assign w1    = wData & wMask;

  function automatic logic [LW-1:0] mergeLines(input logic [LW-1:0] cur,
                                               input logic [LW-1:0] msk,
                                               input logic [LW-1:0] dat);
    return (cur & ~msk) | (dat & msk);
  endfunction

  gpio_dual_irq_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .pinNow  (pinIn),
    .pinPrev (inReg),
    .isInput (oeMask),
    .lowDet  (lowQ),
    .highDet (highQ),
    .riseDet (riseQ),
    .fallDet (fallQ),
    .evt     (evt)
  );

  assign wakeGate = cfgQ[2] && (cfgQ[4:3] != 2'b00) && |(evt & wakeEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statA <= '0; statB <= '0; enA <= '0; enB <= '0; wakeEn <= '0;
      oeMask <= '1; doutQ <= '0; lowQ <= '0; highQ <= '0;
      riseQ <= '0; fallQ <= '0; dbEnQ <= '0; ctrlQ <= '0; dbTimeQ <= '0;
      cfgQ <= '0; resetDone <= 1'b0; wakeReq <= 1'b0; inReg <= '0;
    end else if (strb.softRst) begin
      statA <= '0; statB <= '0; enA <= '0; enB <= '0; wakeEn <= '0;
      oeMask <= '1; doutQ <= '0; lowQ <= '0; highQ <= '0;
      riseQ <= '0; fallQ <= '0; dbEnQ <= '0; ctrlQ <= '0; dbTimeQ <= '0;
      cfgQ <= strb.cfgNext & CFG_KEEP;
      resetDone <= 1'b0; wakeReq <= 1'b0; inReg <= pinIn;
    end else begin
      resetDone <= 1'b1;
      inReg     <= pinIn;
      statA <= (statA & ~(strb.wrStatA ? w1 : '0)) | evt;
      statB <= (statB & ~(strb.wrStatB ? w1 : '0)) | evt;

      if (strb.wrEnA)       enA <= mergeLines(enA, wMask, wData);
      else if (strb.setEnA) enA <= enA | w1;
      else if (strb.clrEnA) enA <= enA & ~w1;

      if (strb.wrEnB)       enB <= mergeLines(enB, wMask, wData);
      else if (strb.setEnB) enB <= enB | w1;
      else if (strb.clrEnB) enB <= enB & ~w1;

      if (strb.wrWake)       wakeEn <= mergeLines(wakeEn, wMask, wData);
      else if (strb.setWake) wakeEn <= wakeEn | w1;
      else if (strb.clrWake) wakeEn <= wakeEn & ~w1;

      if (strb.wrDout)       doutQ <= mergeLines(doutQ, wMask, wData);
      else if (strb.setDout) doutQ <= doutQ | w1;
      else if (strb.clrDout) doutQ <= doutQ & ~w1;

      if (strb.wrOe)   oeMask <= mergeLines(oeMask, wMask, wData);
      if (strb.wrLow)  lowQ   <= mergeLines(lowQ, wMask, wData);
      if (strb.wrHigh) highQ  <= mergeLines(highQ, wMask, wData);
      if (strb.wrRise) riseQ  <= mergeLines(riseQ, wMask, wData);
      if (strb.wrFall) fallQ  <= mergeLines(fallQ, wMask, wData);
      if (strb.wrDbEn) dbEnQ  <= mergeLines(dbEnQ, wMask, wData);
      if (strb.wrCtrl)
        ctrlQ <= (ctrlQ & ~strb.mask[CTRL_W-1:0]) | (strb.wdata[CTRL_W-1:0] & strb.mask[CTRL_W-1:0]);
      if (strb.wrDbTime)
        dbTimeQ <= (dbTimeQ & ~strb.mask[DBT_W-1:0]) | (strb.wdata[DBT_W-1:0] & strb.mask[DBT_W-1:0]);

      if (strb.wrCfg) begin
        cfgQ    <= strb.cfgNext & CFG_KEEP;
        wakeReq <= 1'b0;
      end else if (wakeGate) begin
        wakeReq <= 1'b1;
      end
    end
  end

  assign irqA     = |(statA & enA);
  assign irqB     = |(statB & enB);
  assign pinOut   = doutQ & ~oeMask;
  assign pinDrive = ~oeMask;
  assign cfgCur   = cfgQ;

  always_comb begin
    busRdata = '0;
    unique case (strb.wordIdx)
      W_REV:                    busRdata = REV_ID;
      W_CFG:                    busRdata = REG_W'(cfgQ);
      W_SSTAT:                  busRdata = REG_W'(resetDone);
      W_STATA:                  busRdata = REG_W'(statA);
      W_STATB:                  busRdata = REG_W'(statB);
      W_ENA, W_SETENA, W_CLRENA: busRdata = REG_W'(enA);
      W_ENB, W_SETENB, W_CLRENB: busRdata = REG_W'(enB);
      W_WAKE, W_SETWK, W_CLRWK:  busRdata = REG_W'(wakeEn);
      W_CTRL:                   busRdata = REG_W'(ctrlQ);
      W_OE:                     busRdata = REG_W'(oeMask);
      W_DIN:                    busRdata = REG_W'(inReg);
      W_DOUT, W_SETDO, W_CLRDO:  busRdata = REG_W'(doutQ);
      W_LOW:                    busRdata = REG_W'(lowQ);
      W_HIGH:                   busRdata = REG_W'(highQ);
      W_RISE:                   busRdata = REG_W'(riseQ);
      W_FALL:                   busRdata = REG_W'(fallQ);
      W_DBEN:                   busRdata = REG_W'(dbEnQ);
      W_DBTIME:                 busRdata = REG_W'(dbTimeQ);
      default:                  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq
  import gpio_dual_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter logic [31:0] REV_ID = 32'h0000_0025
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busEn,
  input  logic                 busWrite,
  input  logic [5:0]           busAddr,
  input  logic [3:0]           busBe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinDrive,
  output logic                 irqA,
  output logic                 irqB,
  output logic                 wakeReq,
  output logic                 cfgErr
);

  strobe_t          strb;
  logic [CFG_W-1:0] cfgCur;

  gpio_dual_irq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busEn    (busEn),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busBe    (busBe),
    .busWdata (busWdata),
    .cfgCur   (cfgCur),
    .strb     (strb),
    .cfgErr   (cfgErr)
  );

  gpio_dual_irq_dp #(.NUM_LINES(NUM_LINES), .REV_ID(REV_ID)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pinIn    (pinIn),
    .busRdata (busRdata),
    .pinOut   (pinOut),
    .pinDrive (pinDrive),
    .irqA     (irqA),
    .irqB     (irqB),
    .wakeReq  (wakeReq),
    .cfgCur   (cfgCur)
  );

endmodule

// File: rtl/gpio_dual_irq_chk.sv
module gpio_dual_irq_chk
  import gpio_dual_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input strobe_t              strb,
  input logic [NUM_LINES-1:0] statA,
  input logic [NUM_LINES-1:0] statB,
  input logic [CFG_W-1:0]     cfg,
  input logic                 wakeReq,
  input logic                 cfgErr,
  input logic [NUM_LINES-1:0] pinOut
);

  // R4: without a clear, no status bit of bank A is ever lost
  assert_stat_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wrStatA && !strb.softRst) |=> ((statA & $past(statA)) == $past(statA)));

  // R2: a bit newly set in bank A is set in bank B as well
  assert_banks_together_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statA & ~$past(statA) & ~statB) == '0));

  // R9: a wakeup request only rises while the gate bits were open
  assert_wake_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReq) |-> ($past(cfg[2]) && ($past(cfg[4:3]) != 2'b00)));

  // R8: the illegal idle code is never stored
  assert_cfg_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfg[4:3] != 2'b11);

  // R8: a rejected write leaves sysconfig untouched
  assert_cfg_reject_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $stable(cfg));

  // R6: output pins move only after a write touching data-out or direction
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrDout || strb.setDout || strb.clrDout || strb.wrOe || strb.softRst)
      |=> $stable(pinOut));

endmodule

bind gpio_dual_irq gpio_dual_irq_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .strb    (strb),
  .statA   (u_dp.statA),
  .statB   (u_dp.statB),
  .cfg     (cfgCur),
  .wakeReq (wakeReq),
  .cfgErr  (cfgErr),
  .pinOut  (pinOut)
);

// File: tb/gpio_dual_irq_tb.sv
module gpio_dual_irq_tb;

  localparam int CLK_P = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busEn = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] pinIn = '0;
  logic [N-1:0] pinOut, pinDrive;
  logic irqA, irqB, wakeReq, cfgErr;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_dual_irq #(.NUM_LINES(N), .REV_ID(32'h0000_0025)) u_dut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWrite(busWrite),
    .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinDrive(pinDrive),
    .irqA(irqA), .irqB(irqB), .wakeReq(wakeReq), .cfgErr(cfgErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwReset();
    @(negedge clk);
    rstN = 1'b0; pinIn = '0; busEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWrite = 1'b1; busAddr = a[7:2]; busBe = be; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWrite = 1'b0; busBe = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a[7:2];
    #1 d = busRdata;
  endtask

  task automatic setPins(input logic [N-1:0] v);
    @(negedge clk);
    pinIn = v;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    hwReset();

    // R1 reset state
    rd(8'h34, v); check("R1 oe reset", v, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R1 statA reset", v, 0);
    rd(8'h1C, v); check("R1 enA reset", v, 0);
    rd(8'h10, v); check("R1 cfg reset", v, 0);
    rd(8'h14, v); check("R1 sysstatus", v, 1);
    rd(8'h00, v); check("R1 revision", v, 32'h25);
    check("R1 irqA reset", {31'b0, irqA}, 0);
    check("R1 pinOut reset", pinOut, 0);

    // R2 R5 rising edge on line 0, bank A only enabled
    wr(8'h48, 4'hF, 32'h1);
    wr(8'h1C, 4'hF, 32'h1);
    setPins(32'h1);
    check("R5 irqA after rise", {31'b0, irqA}, 1);
    check("R5 irqB disabled", {31'b0, irqB}, 0);
    rd(8'h18, v); check("R2 statA rise", v, 1);
    rd(8'h28, v); check("R2 statB rise", v, 1);
    wr(8'h18, 4'hF, 32'h1);
    check("R5 irqA after clear", {31'b0, irqA}, 0);
    rd(8'h18, v); check("R3 statA cleared", v, 0);
    rd(8'h28, v); check("R4 statB kept", v, 1);

    // R3 level re-assert, R4 output lines ignored
    hwReset();
    wr(8'h44, 4'hF, 32'h2);
    setPins(32'h2);
    wr(8'h18, 4'hF, 32'h2);
    rd(8'h18, v); check("R3 high level re-asserts", v, 32'h2);
    setPins(32'h0);
    wr(8'h18, 4'hF, 32'h2);
    rd(8'h18, v); check("R3 clear after level gone", v, 0);
    wr(8'h34, 4'hF, ~32'h4);
    wr(8'h48, 4'hF, 32'h4);
    setPins(32'h4);
    rd(8'h18, v); check("R4 output line no event", v, 0);

    // R2 falling, R3 low level
    hwReset();
    wr(8'h4C, 4'hF, 32'h8);
    setPins(32'h8);
    rd(8'h18, v); check("R2 no fall on rise", v, 0);
    wr(8'h40, 4'hF, 32'h10);
    setPins(32'h0);
    rd(8'h18, v); check("R2 R3 fall and low", v, 32'h18);

    // R2 R5 sweep every line through bank B
    for (int i = 0; i < N; i++) begin
      hwReset();
      wr(8'h48, 4'hF, 32'h1 << i);
      wr(8'h2C, 4'hF, 32'h1 << i);
      setPins('1);
      check("R5 sweep irqB", {31'b0, irqB}, 1);
      check("R5 sweep irqA", {31'b0, irqA}, 0);
      rd(8'h28, v); check("R2 sweep statB", v, 32'h1 << i);
    end

    // R6 R7 data out and aliases
    hwReset();
    wr(8'h3C, 4'hF, 32'hA5);
    check("R6 inputs drive 0", pinOut, 0);
    wr(8'h34, 4'hF, 32'hFFFF_FF00);
    check("R6 pinOut", pinOut, 32'hA5);
    check("R6 pinDrive", pinDrive, 32'hFF);
    wr(8'h94, 4'hF, 32'h100);
    rd(8'h3C, v); check("R7 set dout", v, 32'h1A5);
    check("R6 input bit not driven", pinOut, 32'hA5);
    wr(8'h90, 4'hF, 32'h5);
    rd(8'h94, v); check("R7 clr dout alias read", v, 32'h1A0);
    check("R6 pinOut after clear", pinOut, 32'hA0);
    wr(8'h64, 4'hF, 32'hF00);
    wr(8'h60, 4'hF, 32'h100);
    rd(8'h60, v); check("R7 enA aliases", v, 32'hE00);
    wr(8'h84, 4'hF, 32'h30);
    wr(8'h80, 4'hF, 32'h10);
    rd(8'h20, v); check("R7 wake aliases", v, 32'h20);

    // R10 byte lanes
    hwReset();
    wr(8'h48, 4'hF, 32'hFFFF_FFFF);
    setPins('1);
    wr(8'h18, 4'b1000, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R10 status byte clear", v, 32'h00FF_FFFF);
    wr(8'h48, 4'hF, 32'h1122_3344);
    wr(8'h48, 4'b0010, 32'h0000_AA00);
    rd(8'h48, v); check("R10 rmw byte", v, 32'h1122_AA44);
    wr(8'h74, 4'b0100, 32'hFFFF_FFFF);
    rd(8'h2C, v); check("R10 set alias byte", v, 32'h00FF_0000);
    wr(8'h70, 4'b0001, 32'hFFFF_FFFF);
    rd(8'h74, v); check("R10 clr alias other byte", v, 32'h00FF_0000);

    // R11 read-only and narrow registers
    hwReset();
    wr(8'h00, 4'hF, 32'h0);
    rd(8'h00, v); check("R11 revision read-only", v, 32'h25);
    wr(8'h38, 4'hF, 32'hFFFF_FFFF);
    rd(8'h38, v); check("R11 data-in read-only", v, 0);
    pinIn = 32'h5A;
    rd(8'h38, v); check("R11 data-in value", v, 32'h5A);
    wr(8'h30, 4'hF, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R11 ctrl 3 bits", v, 32'h7);
    wr(8'h54, 4'hF, 32'hFFFF_FFFF);
    rd(8'h54, v); check("R11 debounce time 8 bits", v, 32'hFF);
    wr(8'h50, 4'hF, 32'hFFFF_FFFF);
    rd(8'h50, v); check("R11 debounce enable", v, 32'hFFFF_FFFF);
    rd(8'h18, v); check("R11 debounce no effect", v, 0);

    // R8 sysconfig
    hwReset();
    wr(8'h10, 4'hF, 32'h1F);
    check("R8 illegal idle flagged", {31'b0, cfgErr}, 1);
    rd(8'h10, v); check("R8 illegal idle ignored", v, 0);
    check("R8 error pulse one cycle", {31'b0, cfgErr}, 0);
    wr(8'h10, 4'hF, 32'hE5);
    rd(8'h10, v); check("R8 keep mask", v, 32'h05);
    wr(8'h1C, 4'hF, 32'hFF);
    wr(8'h34, 4'hF, 32'h0);
    wr(8'h10, 4'hF, 32'h06);
    rd(8'h1C, v); check("R8 soft reset enA", v, 0);
    rd(8'h34, v); check("R8 soft reset oe", v, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R8 soft reset cfg kept", v, 32'h04);
    rd(8'h14, v); check("R8 sysstatus after soft reset", v, 1);

    // R9 wakeup gating
    hwReset();
    wr(8'h20, 4'hF, 32'h8);
    wr(8'h48, 4'hF, 32'h208);
    wr(8'h10, 4'hF, 32'h04);
    setPins(32'h8);
    check("R9 idle zero blocks", {31'b0, wakeReq}, 0);
    setPins(32'h0);
    wr(8'h10, 4'hF, 32'h08);
    setPins(32'h8);
    check("R9 enable bit blocks", {31'b0, wakeReq}, 0);
    setPins(32'h0);
    wr(8'h10, 4'hF, 32'h0C);
    setPins(32'h200);
    check("R9 line not enabled", {31'b0, wakeReq}, 0);
    setPins(32'h208);
    check("R9 wakeup raised", {31'b0, wakeReq}, 1);
    setPins(32'h208);
    check("R9 wakeup held", {31'b0, wakeReq}, 1);
    wr(8'h10, 4'hF, 32'h0C);
    check("R9 cleared by cfg write", {31'b0, wakeReq}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule